// File: doc/BRIEF.md
# I2C Line Filter and Override Front End

This block sits between the I2C pads and the master protocol engine. Each of the two bus lines, clock and data, is taken into the core clock domain through a two-stage synchroniser. It then passes a glitch filter whose rejection window is a programmable number of core clocks. A typical setting covers about 50 ns. The filtered levels go to the engine and also appear in a small monitor word that software can read.

For bus recovery, software can hold either line low on its own through two override bits. This lets it clock a stuck clock line by hand until a slave releases the data line. Each line has per-bit write strobes, so changing one override never disturbs the other. The open-drain enable of each pad is the OR of the engine's pull-down request and the override bit for that line. The block never drives a line high.

Top module: `i2c_line_frontend`

## Requirements
- R1: While reset is asserted and directly after it, `mon_o` reads 4'b0011: both levels high and both overrides clear. Both open-drain enables are 0.
- R2: The `mon_o` bits [0] and `scl_lvl_o` carry the filtered clock level. The `mon_o` bit [1] and `sda_lvl_o` carry the filtered data level.
- R3: A write with `ctl_we_i[0]` set loads `ctl_d_i[0]` into the clock override. The new value is visible in `mon_o[2]` after the capturing edge, and while it is 1, `scl_oe_o` is 1.
- R4: A write with `ctl_we_i[1]` set loads `ctl_d_i[1]` into the data override. The new value is visible in `mon_o[3]` after the capturing edge, and while it is 1, `sda_oe_o` is 1.
- R5: An override bit whose write strobe is 0 keeps its value, whatever `ctl_d_i` carries in that bit.
- R6: With `flt_len_i` = N, a change of a raw input that lasts N clocks or fewer never reaches the filtered level.
- R7: With `flt_len_i` = N, a raw input change that is held from before a rising edge A appears on the filtered level after edge A+N+2. It does not appear earlier.
- R8: With `flt_len_i` = 0, every raw change, including a single-clock pulse, reaches the filtered level after edge A+2.
- R9: Each open-drain enable equals the engine pull-down request OR the matching override bit. No output drives a line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw clock line from pad |
| sda_i | input | 1 | Raw data line from pad |
| flt_len_i | input | FLT_W | Glitch rejection length in core clocks |
| ctl_we_i | input | 2 | Override write strobes: [0] clock, [1] data |
| ctl_d_i | input | 2 | Override write data: [0] clock, [1] data (1 = hold low) |
| eng_scl_pull_i | input | 1 | Engine request to pull clock low |
| eng_sda_pull_i | input | 1 | Engine request to pull data low |
| scl_lvl_o | output | 1 | Filtered clock level |
| sda_lvl_o | output | 1 | Filtered data level |
| mon_o | output | 4 | Monitor word {data override, clock override, data level, clock level} |
| scl_oe_o | output | 1 | Clock pad pull-down enable |
| sda_oe_o | output | 1 | Data pad pull-down enable |

## Verification
The hardest case to reach is a pulse whose length sits exactly at the filter boundary. A pulse of N clocks must be dropped, and one of N+1 clocks must pass on precisely the (N+3)th edge. This can only be seen from the ports through two synchroniser stages. The stimulus drives raw pulses of exactly N and N+1 clocks, with N = 4 and with N = 0, and samples the level one edge before and on the expected edge. A long random phase then changes the filter length while pulses are in flight, which stresses a counter that is part-way through a window when the limit changes. A behavioural model is compared with the outputs on every clock throughout.

// File: rtl/i2c_fe_pkg.sv
package i2c_fe_pkg;
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned MON_W     = 2 * NUM_LINES;

  typedef enum int unsigned {
    LINE_SCL = 0,
    LINE_SDA = 1
  } line_e;

  localparam logic LINE_IDLE = 1'b1;
endpackage

// File: rtl/i2c_fe_sync.sv
module i2c_fe_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_fe_filter.sv
module i2c_fe_filter #(
  parameter int unsigned CNT_W   = 8,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] len_i,
  input  logic             d_i,
  output logic             q_o
);
  logic             lvl_q;
  logic [CNT_W-1:0] run_q;
  logic             differ;
  logic             expire;

  assign differ = d_i ^ lvl_q;
  assign expire = (run_q >= len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= RST_VAL;
      run_q <= '0;
    end else if (!differ) begin
      run_q <= '0;
    end else if (expire) begin
      lvl_q <= d_i;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign q_o = lvl_q;

  // R6
  quiet_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_i == lvl_q) |=> $stable(lvl_q));

  // R7
  new_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(d_i)));

  // R8
  zero_len_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((len_i == '0) && (d_i != lvl_q)) |=> (lvl_q == $past(d_i)));
endmodule

// File: rtl/i2c_fe_override.sv
module i2c_fe_override #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] we_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] force_o
);
  logic [N-1:0] force_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     force_q[g] <= 1'b0;
      else if (we_i[g]) force_q[g] <= d_i[g];
    end

    // R5
    keep_unwritten_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i[g] |=> $stable(force_q[g]));
  end

  assign force_o = force_q;
endmodule

// File: rtl/i2c_line_frontend.sv
module i2c_line_frontend
  import i2c_fe_pkg::*;
#(
  parameter int unsigned FLT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [FLT_W-1:0] flt_len_i,
  input  logic [1:0]       ctl_we_i,
  input  logic [1:0]       ctl_d_i,
  input  logic             eng_scl_pull_i,
  input  logic             eng_sda_pull_i,
  output logic             scl_lvl_o,
  output logic             sda_lvl_o,
  output logic [3:0]       mon_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o
);
  logic [NUM_LINES-1:0] raw;
  logic [NUM_LINES-1:0] synced;
  logic [NUM_LINES-1:0] filt;
  logic [NUM_LINES-1:0] pull;
  logic [NUM_LINES-1:0] frc;
  logic [NUM_LINES-1:0] oe;

  assign raw[LINE_SCL]  = scl_i;
  assign raw[LINE_SDA]  = sda_i;
  assign pull[LINE_SCL] = eng_scl_pull_i;
  assign pull[LINE_SDA] = eng_sda_pull_i;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    i2c_fe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_IDLE)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[l]),
      .q_o   (synced[l])
    );

    i2c_fe_filter #(.CNT_W(FLT_W), .RST_VAL(LINE_IDLE)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .len_i (flt_len_i),
      .d_i   (synced[l]),
      .q_o   (filt[l])
    );

    // open drain: only ever pull low
    assign oe[l] = pull[l] | frc[l];
  end

  i2c_fe_override #(.N(NUM_LINES)) u_ovr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctl_we_i),
    .d_i    (ctl_d_i),
    .force_o(frc)
  );

  assign scl_lvl_o = filt[LINE_SCL];
  assign sda_lvl_o = filt[LINE_SDA];
  assign mon_o     = {frc[LINE_SDA], frc[LINE_SCL], filt[LINE_SDA], filt[LINE_SCL]};
  assign scl_oe_o  = oe[LINE_SCL];
  assign sda_oe_o  = oe[LINE_SDA];

  // R3
  scl_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i[0] && ctl_d_i[0]) |=> (mon_o[2] && scl_oe_o));

  // R4
  sda_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i[1] && ctl_d_i[1]) |=> (mon_o[3] && sda_oe_o));

  // R9
  scl_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eng_scl_pull_i && !mon_o[2]) |-> !scl_oe_o);

  // R9
  sda_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eng_sda_pull_i && !mon_o[3]) |-> !sda_oe_o);
endmodule

// File: tb/i2c_line_frontend_test.sv
module i2c_line_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic [FW-1:0] len = '0;
  logic [1:0] we = '0, wd = '0;
  logic pull_scl = 1'b0, pull_sda = 1'b0;
  logic scl_lvl, sda_lvl, scl_oe, sda_oe;
  logic [3:0] mon;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural model, index 0 = clock line, 1 = data line
  bit m_s1[2], m_s2[2], m_lv[2], m_f[2];
  int m_run[2];

  i2c_line_frontend #(.FLT_W(FW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_in), .sda_i(sda_in),
    .flt_len_i(len), .ctl_we_i(we), .ctl_d_i(wd),
    .eng_scl_pull_i(pull_scl), .eng_sda_pull_i(pull_sda),
    .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl), .mon_o(mon),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_s1[i] = 1; m_s2[i] = 1; m_lv[i] = 1; m_f[i] = 0; m_run[i] = 0;
      end
    end else begin
      bit raw[2];
      raw[0] = scl_in; raw[1] = sda_in;
      for (int i = 0; i < 2; i++) begin
        if (m_s2[i] != m_lv[i]) begin
          m_run[i] = m_run[i] + 1;
          if (m_run[i] > int'(len)) begin m_lv[i] = m_s2[i]; m_run[i] = 0; end
        end else m_run[i] = 0;
        m_s2[i] = m_s1[i];
        m_s1[i] = raw[i];
        if (we[i]) m_f[i] = wd[i];
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk("R2 clock level in monitor", mon[0], m_lv[0]);
    chk("R2 clock level output", scl_lvl, m_lv[0]);
    chk("R2 data level in monitor", mon[1], m_lv[1]);
    chk("R2 data level output", sda_lvl, m_lv[1]);
    chk("R3 clock override bit", mon[2], m_f[0]);
    chk("R4 data override bit", mon[3], m_f[1]);
    chk("R9 clock enable", scl_oe, pull_scl | m_f[0]);
    chk("R9 data enable", sda_oe, pull_sda | m_f[1]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 monitor in reset", mon, 4'b0011);
    chk("R1 enables in reset", {sda_oe, scl_oe}, 0);
    rst_n = 1'b1;
    step();
    chk("R1 monitor after reset", mon, 4'b0011);

    // R6: pulse of exactly N clocks is dropped
    len = 4;
    repeat (3) step();
    scl_in = 0;
    repeat (4) step();
    scl_in = 1;
    for (int k = 0; k < 10; k++) begin
      step();
      chk("R6 short clock pulse rejected", mon[0], 1);
    end

    // R7: held change appears on edge A+N+2
    scl_in = 0;
    repeat (6) step();
    chk("R7 level not early", mon[0], 1);
    step();
    chk("R7 level on expected edge", mon[0], 0);
    scl_in = 1;
    repeat (8) step();
    chk("R7 level back high", mon[0], 1);

    // R8: zero length passes everything
    len = 0;
    sda_in = 0;
    repeat (2) step();
    chk("R8 data not early", mon[1], 1);
    step();
    chk("R8 data follows", mon[1], 0);
    sda_in = 1;
    repeat (3) step();
    chk("R8 data back high", mon[1], 1);
    sda_in = 0;
    step();
    sda_in = 1;
    repeat (2) step();
    chk("R8 single clock pulse passes", mon[1], 0);
    step();
    chk("R8 pulse ends", mon[1], 1);

    // R3, R4, R5: independent overrides
    we = 2'b01; wd = 2'b01; step(); we = 0;
    chk("R3 clock override set", mon[3:2], 2'b01);
    chk("R3 clock enable forced", scl_oe, 1);
    we = 2'b10; wd = 2'b10; step(); we = 0;
    chk("R4 data override set", mon[3:2], 2'b11);
    chk("R4 data enable forced", sda_oe, 1);
    we = 2'b01; wd = 2'b10; step(); we = 0;
    chk("R5 data override kept", mon[3:2], 2'b10);
    we = 2'b10; wd = 2'b01; step(); we = 0;
    chk("R5 clock override kept clear", mon[3:2], 2'b00);

    // R9: engine requests alone
    pull_scl = 1; step();
    chk("R9 engine clock pull", {sda_oe, scl_oe}, 2'b01);
    pull_scl = 0; pull_sda = 1; step();
    chk("R9 engine data pull", {sda_oe, scl_oe}, 2'b10);
    pull_sda = 0; step();
    chk("R9 all released", {sda_oe, scl_oe}, 2'b00);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      if (c % 250 == 0) begin
        case ($urandom % 5)
          0: len = 0; 1: len = 1; 2: len = 2; 3: len = 5; default: len = 9;
        endcase
      end
      if ($urandom % 4 == 0) scl_in = ~scl_in;
      if ($urandom % 5 == 0) sda_in = ~sda_in;
      we = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      wd = 2'($urandom);
      pull_scl = ($urandom % 3 == 0);
      pull_sda = ($urandom % 3 == 0);
      step();
    end

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule